// File: doc/BRIEF.md
# Prioritised ADC Conversion Arbiter

One analog-to-digital converter is shared by three classes of requester. Motor-control and power-factor loops form the urgent class. Eight user channels form the middle class. Housekeeping measurements form the background class: die temperature, logic supply and calibration. The arbiter latches every request pulse into a pending bit. Whenever the converter is idle, it picks exactly one source, emits a one-cycle start strobe with the source index, and then waits for the converter's done pulse before it picks again.

User channels are sampled in one of two modes. In free-running mode, a pending user channel takes the converter as soon as no urgent request is waiting. In locked mode, user sampling is tied to the DC-bus measurement. Each finished DC-bus conversion opens a single user slot, and only if some user channel is waiting at that moment. The slot survives urgent requests that are still queued, but it grants only one user conversion. This keeps user sampling in the quiet window after the bus sample and limits it to one per PWM period.

Source indices are laid out as follows: urgent sources first (0 = DC bus / motor control, 1 = power-factor control), then user channel u at index 2+u, then housekeeping h at index 10+h.

Top module: `adc_slot_arbiter`

## Requirements
- R1: After reset, conv_start_o is 0 and conv_src_o is 0, no source is pending, and no start occurs until a request arrives.
- R2: At most one conversion is in flight. After a start, no further start occurs until conv_done_i has been seen.
- R3: When the converter is idle and any urgent request (index 0 or 1) is pending, the next start selects the lowest pending urgent index, ahead of any user or housekeeping request.
- R4: Among eligible pending user channels, the lowest-numbered channel is granted first (source 2+u).
- R5: Housekeeping sources (10..12, lowest first) are granted only when no urgent request and no eligible user request is pending.
- R6: With async_mode_i = 1, a pending user channel is granted at the first idle cycle in which no urgent request is pending.
- R7: With async_mode_i = 0, a user channel is granted only after a DC-bus conversion (source 0) has completed, and each such completion admits at most one user grant.
- R8: With async_mode_i = 0, if no user channel is pending when a DC-bus conversion completes, that slot is lost. Later user requests wait for the next DC-bus completion.
- R9: Each request pulse yields exactly one conversion of that source. Its pending flag drops when the source is granted.
- R10: A request for a source that arrives while that same source is being converted is kept and served by a further conversion.
- R11: conv_done_i while no conversion is in flight has no effect.
- R12: conv_start_o is high for exactly one cycle per grant, and conv_src_o stays stable until the next grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_mode_i | input | 1 | 1 = free-running user sampling, 0 = locked to DC-bus completion |
| hp_req_i | input | 2 | Urgent request pulses (bit 0 DC bus, bit 1 power-factor) |
| user_req_i | input | 8 | User channel request pulses |
| hk_req_i | input | 3 | Housekeeping request pulses |
| conv_done_i | input | 1 | Converter finished the current conversion |
| conv_start_o | output | 1 | One-cycle start strobe |
| conv_src_o | output | 4 | Index of the granted source |

## Verification
Several properties are checked on every cycle. No start occurs while a conversion is open. An idle cycle with urgent work pending produces an urgent grant, and the user grant goes to the lowest eligible channel. In locked mode, no user grant is issued without a slot, and a bus completion with nothing waiting leaves no slot behind. The strobe lasts one cycle, and the source holds steady during a conversion. Only the bench scenarios can show the complete grant orders for mixed request sets, the loss of a slot followed by its recovery at the next bus sample, re-requests made during a conversion, and the absence of any spurious grant after a stray done pulse.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HP   = 2'd1,
    CLS_USER = 2'd2,
    CLS_HK   = 2'd3
  } grant_cls_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/adc_arb_pick.sv
module adc_arb_pick #(
  parameter  int N = 8,
  localparam int W = adc_arb_pkg::idx_w(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] oh_o
);

  // lowest index wins: scan downwards so the last hit is the lowest
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = W'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_arb_pend.sv
module adc_arb_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  // a new request wins over the clear of the same bit
  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_req_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)))
    else $error("request pulse not latched");

endmodule

// File: rtl/adc_arb_slot.sv
module adc_arb_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic dc_done_i,
  input  logic user_any_i,
  input  logic take_i,
  output logic slot_o
);

  logic slot_q;
  logic slot_d;

  always_comb begin
    slot_d = slot_q;
    if (async_i)                       slot_d = 1'b0;
    else if (dc_done_i && user_any_i)  slot_d = 1'b1;
    else if (dc_done_i)                slot_d = 1'b0;
    else if (take_i)                   slot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= slot_d;
  end

  assign slot_o = slot_q;

  p_slot_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_done_i && !user_any_i) |=> !slot_o)
    else $error("slot opened with no user waiting");

  p_one_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !dc_done_i) |=> !slot_o)
    else $error("slot survived a user grant");

endmodule

// File: rtl/adc_slot_arbiter.sv
module adc_slot_arbiter #(
  parameter int NUM_HP    = 2,
  parameter int NUM_USER  = 8,
  parameter int NUM_HK    = 3,
  parameter int DCBUS_IDX = 0,
  localparam int NUM_SRC  = NUM_HP + NUM_USER + NUM_HK,
  localparam int SRC_W    = adc_arb_pkg::idx_w(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                async_mode_i,
  input  logic [NUM_HP-1:0]   hp_req_i,
  input  logic [NUM_USER-1:0] user_req_i,
  input  logic [NUM_HK-1:0]   hk_req_i,
  input  logic                conv_done_i,
  output logic                conv_start_o,
  output logic [SRC_W-1:0]    conv_src_o
);
  import adc_arb_pkg::*;

  localparam int HP_W = idx_w(NUM_HP);
  localparam int US_W = idx_w(NUM_USER);
  localparam int HK_W = idx_w(NUM_HK);
  localparam logic [SRC_W-1:0] USR_BASE = SRC_W'(NUM_HP);
  localparam logic [SRC_W-1:0] HK_BASE  = SRC_W'(NUM_HP + NUM_USER);
  localparam logic [SRC_W-1:0] DC_SRC   = SRC_W'(DCBUS_IDX);

  // pending state
  logic [NUM_HP-1:0]   hp_pend,  hp_clr,  hp_oh;
  logic [NUM_USER-1:0] us_pend,  us_clr,  us_oh;
  logic [NUM_HK-1:0]   hk_pend,  hk_clr,  hk_oh;
  logic                hp_any, us_any, hk_any;
  logic [HP_W-1:0]     hp_idx;
  logic [US_W-1:0]     us_idx;
  logic [HK_W-1:0]     hk_idx;

  // control state
  logic             busy_q, busy_d;
  logic             start_q, start_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             slot;
  logic             user_elig;
  logic             done_fire;
  logic             dc_done;
  grant_cls_e       gcls;
  logic [SRC_W-1:0] win_src;

  adc_arb_pend #(.N(NUM_HP)) u_hp_pend (
    .clk(clk), .rst_n(rst_n), .set_i(hp_req_i), .clr_i(hp_clr), .pend_o(hp_pend));
  adc_arb_pend #(.N(NUM_USER)) u_us_pend (
    .clk(clk), .rst_n(rst_n), .set_i(user_req_i), .clr_i(us_clr), .pend_o(us_pend));
  adc_arb_pend #(.N(NUM_HK)) u_hk_pend (
    .clk(clk), .rst_n(rst_n), .set_i(hk_req_i), .clr_i(hk_clr), .pend_o(hk_pend));

  adc_arb_pick #(.N(NUM_HP)) u_hp_pick (
    .req_i(hp_pend), .any_o(hp_any), .idx_o(hp_idx), .oh_o(hp_oh));
  adc_arb_pick #(.N(NUM_USER)) u_us_pick (
    .req_i(us_pend), .any_o(us_any), .idx_o(us_idx), .oh_o(us_oh));
  adc_arb_pick #(.N(NUM_HK)) u_hk_pick (
    .req_i(hk_pend), .any_o(hk_any), .idx_o(hk_idx), .oh_o(hk_oh));

  assign done_fire = busy_q & conv_done_i;
  assign dc_done   = done_fire & (src_q == DC_SRC);
  assign user_elig = async_mode_i | slot;

  adc_arb_slot u_slot (
    .clk(clk), .rst_n(rst_n), .async_i(async_mode_i), .dc_done_i(dc_done),
    .user_any_i(us_any), .take_i(gcls == CLS_USER), .slot_o(slot));

  // class selection, only while the converter is idle
  always_comb begin
    gcls    = CLS_NONE;
    win_src = src_q;
    if (!busy_q) begin
      if (hp_any) begin
        gcls    = CLS_HP;
        win_src = SRC_W'(hp_idx);
      end else if (us_any && user_elig) begin
        gcls    = CLS_USER;
        win_src = USR_BASE + SRC_W'(us_idx);
      end else if (hk_any) begin
        gcls    = CLS_HK;
        win_src = HK_BASE + SRC_W'(hk_idx);
      end
    end
  end

  always_comb begin
    hp_clr = (gcls == CLS_HP)   ? hp_oh : '0;
    us_clr = (gcls == CLS_USER) ? us_oh : '0;
    hk_clr = (gcls == CLS_HK)   ? hk_oh : '0;
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    src_d   = src_q;
    if (done_fire) begin
      busy_d = 1'b0;
    end else if (gcls != CLS_NONE) begin
      busy_d  = 1'b1;
      start_d = 1'b1;
      src_d   = win_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      src_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      src_q   <= src_d;
    end
  end

  assign conv_start_o = start_q;
  assign conv_src_o   = src_q;

  p_single_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_done_i) |=> !conv_start_o)
    else $error("start while a conversion is open");

  p_urgent_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hp_any) |=> (conv_start_o && conv_src_o < USR_BASE))
    else $error("urgent request not served first");

  p_lowest_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !hp_any && us_any && user_elig)
      |=> (conv_start_o && conv_src_o == USR_BASE + SRC_W'($past(us_idx))))
    else $error("user grant not lowest channel");

  p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !async_mode_i && !slot)
      |=> !(conv_start_o && conv_src_o >= USR_BASE && conv_src_o < HK_BASE))
    else $error("user granted without a slot");

  p_start_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o)
    else $error("start longer than one cycle");

  p_src_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_start_o) |-> $stable(conv_src_o))
    else $error("source moved during conversion");

endmodule

// File: tb/sim_adc_slot_arbiter.sv
module sim_adc_slot_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  typedef struct packed {
    logic            async_m;
    logic [1:0]      hp;
    logic [7:0]      us;
    logic [2:0]      hk;
    logic [2:0]      n;
    logic [0:3][3:0] exp;
  } vec_t;

  // grant orders derived from R3..R7 and the index layout in the brief
  localparam vec_t VECS [6] = '{
    '{1'b1, 2'b00, 8'b1010_0100, 3'b000, 3'd3, {4'd4, 4'd7, 4'd9, 4'd0}},
    '{1'b1, 2'b10, 8'b0000_0010, 3'b001, 3'd3, {4'd1, 4'd3, 4'd10, 4'd0}},
    '{1'b1, 2'b00, 8'b0000_0000, 3'b110, 3'd2, {4'd11, 4'd12, 4'd0, 4'd0}},
    '{1'b0, 2'b01, 8'b0000_1000, 3'b000, 3'd2, {4'd0, 4'd5, 4'd0, 4'd0}},
    '{1'b0, 2'b11, 8'b0000_0001, 3'b100, 3'd4, {4'd0, 4'd1, 4'd2, 4'd12}},
    '{1'b0, 2'b00, 8'b0000_0000, 3'b011, 3'd2, {4'd10, 4'd11, 4'd0, 4'd0}}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       async_mode;
  logic [1:0] hp_req;
  logic [7:0] user_req;
  logic [2:0] hk_req;
  logic       conv_done;
  logic       conv_start;
  logic [3:0] conv_src;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_slot_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .async_mode_i(async_mode), .hp_req_i(hp_req),
    .user_req_i(user_req), .hk_req_i(hk_req), .conv_done_i(conv_done),
    .conv_start_o(conv_start), .conv_src_o(conv_src));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] hp, input logic [7:0] us, input logic [2:0] hk);
    hp_req = hp; user_req = us; hk_req = hk;
    @(negedge clk);
    hp_req = '0; user_req = '0; hk_req = '0;
  endtask

  task automatic expect_grant(input int exp, input string req);
    int n = 0;
    while (!conv_start && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(conv_start && conv_src == 4'(exp), req, conv_start ? int'(conv_src) : -1, exp);
    @(negedge clk);
    check(!conv_start && conv_src == 4'(exp), "R12", int'(conv_start), 0);
  endtask

  task automatic finish_conv();
    repeat (LAT) @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (conv_start) seen = 1;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; async_mode = 1'b1; hp_req = '0; user_req = '0; hk_req = '0;
    conv_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!conv_start && conv_src == 4'd0, "R1", int'(conv_src), 0);
    rst_n = 1'b1;
    expect_quiet(5, "R1");

    // table of request mixes and grant orders
    for (int v = 0; v < 6; v++) begin
      async_mode = VECS[v].async_m;
      @(negedge clk);
      pulse(VECS[v].hp, VECS[v].us, VECS[v].hk);
      for (int g = 0; g < int'(VECS[v].n); g++) begin
        expect_grant(int'(VECS[v].exp[g]), "R3/R4/R5/R6/R7");
        finish_conv();
      end
      expect_quiet(8, "R9");
    end

    // R11: stray done while idle
    async_mode = 1'b1;
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    expect_quiet(5, "R11");
    pulse(2'b00, 8'b0001_0000, 3'b000);
    expect_grant(6, "R11");
    finish_conv();
    expect_quiet(5, "R9");

    // R10: re-request during own conversion
    pulse(2'b00, 8'b0000_0010, 3'b000);
    expect_grant(3, "R10");
    pulse(2'b00, 8'b0000_0010, 3'b000);
    finish_conv();
    expect_grant(3, "R10");
    finish_conv();
    expect_quiet(5, "R10");

    // R2: urgent request during busy waits for done
    pulse(2'b00, 8'b0000_0100, 3'b000);
    expect_grant(4, "R2");
    pulse(2'b10, 8'h00, 3'b000);
    expect_quiet(6, "R2");
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    expect_grant(1, "R2");
    finish_conv();

    // R8: slot lost, then regained at next bus sample
    async_mode = 1'b0;
    @(negedge clk);
    pulse(2'b01, 8'h00, 3'b000);
    expect_grant(0, "R8");
    finish_conv();
    pulse(2'b00, 8'b0000_0100, 3'b000);
    expect_quiet(10, "R8");
    pulse(2'b01, 8'h00, 3'b000);
    expect_grant(0, "R8");
    finish_conv();
    expect_grant(4, "R7");
    finish_conv();

    // R7: one user grant per bus completion
    pulse(2'b01, 8'b0000_0011, 3'b000);
    expect_grant(0, "R7");
    finish_conv();
    expect_grant(2, "R7");
    finish_conv();
    expect_quiet(8, "R7");
    pulse(2'b01, 8'h00, 3'b000);
    expect_grant(0, "R7");
    finish_conv();
    expect_grant(3, "R7");
    finish_conv();

    // R6: leftover user served at once after mode switch
    pulse(2'b00, 8'b1000_0000, 3'b000);
    expect_quiet(4, "R7");
    async_mode = 1'b1;
    expect_grant(9, "R6");
    finish_conv();
    expect_quiet(5, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule